// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Channel

The block is one receive channel of a packet DMA engine. It follows a chain of buffer descriptors held in memory. Each descriptor is four 32-bit words at consecutive word addresses. The words are, in order: a link to the next descriptor, a buffer base address, a buffer size, and a control/status word.

The channel takes bytes of one packet from a byte stream and packs them into 32-bit words. It stores those words in the descriptor's buffer. When the packet ends, it writes the control/status word back to memory to hand the descriptor back to software. Software gives the channel empty buffers by incrementing a credit register. It starts the chain by writing the address of the first descriptor into a head register. It reads the head register as zero once the channel has reached the end of the chain.

The end-of-queue flag in the written-back status word tells software what happened when it appended a descriptor to a live chain. If the flag is set, the channel has already stopped, and software must restart it by writing the head register again.

Top module: `ldma_rx_chan`

## Requirements
- R1: When the enable bit is 1, the head register is non-zero and the credit count is non-zero, the channel reads the descriptor words at head+0, head+4, head+8 and head+12, in that order. These are the link, the buffer base, the buffer size (low 11 bits used) and the status word.
- R2: Status word bit 29 is the ownership bit. If the fetched status word has bit 29 clear, the channel writes nothing, leaves the credit count unchanged, sets the head register to zero and goes idle.
- R3: Packet bytes are packed little-endian, so the first byte of each group of four goes in bits 7:0. Word k of the packet is written to buffer base + 4*k. Unused bytes of a final partial word are written as zero.
- R4: Bytes beyond the buffer size are accepted from the stream and discarded until the end-of-packet byte. The stored length is the smaller of the packet length and the buffer size.
- R5: On completion the channel writes only the status word, at head+12. Bit 29 is cleared. Bit 28 (end of queue) is set if the link is zero and cleared otherwise. Bits 10:0 hold the stored length. All other bits keep their fetched value.
- R6: After the status write, the head register takes the link value. A zero link leaves the channel idle with head reading 0. A non-zero link makes the channel go on to that descriptor.
- R7: A write to the head register (address 2) takes effect only while the head reads zero. Otherwise the write is ignored.
- R8: Writing the credit register (address 4) with bit 0 set adds one to the credit count. Each status write subtracts one. If both happen in the same cycle, the count does not change. No fetch starts while the count is zero.
- R9: The enable register (address 0, bit 0) must be 1 before a fetch starts. While it is 0, the channel makes no memory request.
- R10: Writing bit 0 of the reset register (address 1) clears enable, head, completion pointer, credit count and channel state at that clock edge. The reset register then reads 1 for exactly one cycle and 0 after that.
- R11: The completion-pointer register (address 3) stores and reads back the value software writes to it. Writing it has no effect on processing.
- R12: A memory request holds its address, write flag and write data stable until the cycle in which the grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_gnt |
| mem_gnt | input | 1 | Memory grant; a transfer completes when req and gnt are both high |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the final byte of a packet |
| rx_ready | output | 1 | Channel accepts a stream byte |

## Verification
Two events can land on the same clock edge. In the first, software adds a credit in the same cycle as the completion write-back that consumes one. The bench watches for the granted status-word write and issues the credit write in that same cycle; the count read afterwards must equal its value before the packet. In the second, software rewrites the head register while a descriptor is still being filled. The rewrite must be dropped, and the transfer log must show the original descriptor being completed with no fetch at the new address.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

    localparam int LEN_W   = 11;
    localparam int OWN_BIT = 29;
    localparam int EOQ_BIT = 28;

    localparam logic [2:0] RA_ENABLE = 3'd0;
    localparam logic [2:0] RA_RESET  = 3'd1;
    localparam logic [2:0] RA_HEAD   = 3'd2;
    localparam logic [2:0] RA_CPL    = 3'd3;
    localparam logic [2:0] RA_CREDIT = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_LINK = 3'd1,
        ST_RD_BUF  = 3'd2,
        ST_RD_SIZE = 3'd3,
        ST_RD_STAT = 3'd4,
        ST_FILL    = 3'd5,
        ST_WR_DATA = 3'd6,
        ST_WR_STAT = 3'd7
    } chan_st_e;

    typedef struct packed {
        chan_st_e         st;
        logic             en;
        logic             srst;
        logic [31:0]      head;
        logic [31:0]      cpl;
        logic [31:0]      link;
        logic [31:0]      base;
        logic [LEN_W-1:0] size;
        logic [31:0]      stat;
        logic [LEN_W-1:0] kept;
        logic             eop;
    } chan_ctx_t;

endpackage

// File: rtl/ldma_packer.sv
module ldma_packer #(
    parameter int DW     = 32,
    parameter int LANE_W = $clog2(DW / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [7:0]        din,
    output logic [DW-1:0]     word,
    output logic [LANE_W-1:0] lane
);
    localparam int BPW = DW / 8;

    typedef struct packed {
        logic [DW-1:0]     word;
        logic [LANE_W-1:0] lane;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clr) begin
            pk_d = '0;
        end else if (push) begin
            pk_d.word[pk_q.lane*8 +: 8] = din;
            pk_d.lane = pk_q.lane + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word = pk_q.word;
    assign lane = pk_q.lane;

    AST_LANE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && pk_q.lane == LANE_W'(BPW - 1)) |=> (pk_q.lane == '0)); // R3
    AST_CLR_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pk_q.word == '0 && pk_q.lane == '0)); // R3

endmodule

// File: rtl/ldma_credit.sv
module ldma_credit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CREDIT_NET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && dec) |=> $stable(cnt_q)); // R8
    AST_CREDIT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && dec && !inc && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/ldma_rx_chan.sv
module ldma_rx_chan
    import ldma_pkg::*;
#(
    parameter int CREDIT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_gnt,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready
);
    localparam int DW     = 32;
    localparam int LANE_W = $clog2(DW / 8);
    localparam logic [LANE_W-1:0] LANE_TOP = '1;
    localparam logic [31:0] CLR_MASK =
        ~((32'd1 << OWN_BIT) | (32'd1 << EOQ_BIT) | ((32'd1 << LEN_W) - 32'd1));

    chan_ctx_t q, d;

    logic              wr_ok, rst_hit, acc, keep;
    logic              pk_clr, pk_push;
    logic [DW-1:0]     pk_word;
    logic [LANE_W-1:0] pk_lane;
    logic              cred_inc, cred_dec;
    logic [CREDIT_W-1:0] cred;
    logic [LEN_W-1:0]  kept_m1;

    ldma_packer #(.DW(DW), .LANE_W(LANE_W)) u_packer (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .push(pk_push),
        .din(rx_data), .word(pk_word), .lane(pk_lane)
    );

    ldma_credit #(.W(CREDIT_W)) u_credit (
        .clk(clk), .rst_n(rst_n), .clr(rst_hit), .inc(cred_inc),
        .dec(cred_dec), .cnt(cred)
    );

    assign wr_ok   = reg_wr && !q.srst;
    assign rst_hit = wr_ok && reg_addr == RA_RESET && reg_wdata[0];
    assign kept_m1 = q.kept - 1'b1;

    always_comb begin
        d         = q;
        d.srst    = 1'b0;
        cred_inc  = 1'b0;
        cred_dec  = 1'b0;
        pk_clr    = 1'b0;
        pk_push   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.head;
        mem_wdata = '0;
        rx_ready  = (q.st == ST_FILL);
        acc       = rx_valid && rx_ready;
        keep      = q.kept < q.size;

        if (wr_ok) begin
            case (reg_addr)
                RA_ENABLE: d.en = reg_wdata[0];
                RA_HEAD:   if (q.head == '0) d.head = reg_wdata;
                RA_CPL:    d.cpl = reg_wdata;
                RA_CREDIT: cred_inc = reg_wdata[0];
                default:   ;
            endcase
        end

        case (q.st)
            ST_IDLE: begin
                if (q.en && q.head != '0 && cred != '0) begin
                    d.st   = ST_RD_LINK;
                    d.kept = '0;
                    d.eop  = 1'b0;
                end
            end
            ST_RD_LINK: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    d.link = mem_rdata;
                    d.st   = ST_RD_BUF;
                end
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = q.head + 32'd4;
                if (mem_gnt) begin
                    d.base = mem_rdata;
                    d.st   = ST_RD_SIZE;
                end
            end
            ST_RD_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = q.head + 32'd8;
                if (mem_gnt) begin
                    d.size = mem_rdata[LEN_W-1:0];
                    d.st   = ST_RD_STAT;
                end
            end
            ST_RD_STAT: begin
                mem_req  = 1'b1;
                mem_addr = q.head + 32'd12;
                if (mem_gnt) begin
                    d.stat = mem_rdata;
                    if (mem_rdata[OWN_BIT]) begin
                        d.st = ST_FILL;
                    end else begin
                        d.head = '0;
                        d.st   = ST_IDLE;
                    end
                end
            end
            ST_FILL: begin
                if (acc) begin
                    if (rx_last) d.eop = 1'b1;
                    if (keep) begin
                        pk_push = 1'b1;
                        d.kept  = q.kept + 1'b1;
                        if (pk_lane == LANE_TOP || rx_last || (q.kept + 1'b1) == q.size)
                            d.st = ST_WR_DATA;
                    end else if (rx_last) begin
                        d.st = ST_WR_STAT;
                    end
                end
            end
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.base + 32'({kept_m1[LEN_W-1:2], 2'b00});
                mem_wdata = pk_word;
                if (mem_gnt) begin
                    pk_clr = 1'b1;
                    d.st   = q.eop ? ST_WR_STAT : ST_FILL;
                end
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.head + 32'd12;
                mem_wdata = (q.stat & CLR_MASK)
                          | ((q.link == '0) ? (32'd1 << EOQ_BIT) : 32'd0)
                          | 32'(q.kept);
                if (mem_gnt) begin
                    cred_dec = 1'b1;
                    d.head   = q.link;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (rst_hit) begin
            d      = '0;
            d.srst = 1'b1;
            pk_clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RA_ENABLE: reg_rdata = {31'd0, q.en};
            RA_RESET:  reg_rdata = {31'd0, q.srst};
            RA_HEAD:   reg_rdata = q.head;
            RA_CPL:    reg_rdata = q.cpl;
            RA_CREDIT: reg_rdata = 32'(cred);
            default:   reg_rdata = '0;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !rst_hit) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !q.en) |=> (q.st == ST_IDLE)); // R9
    AST_NO_DRY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && cred == '0) |=> (q.st == ST_IDLE)); // R8
    AST_HEAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && !rst_hit && !(mem_gnt && (q.st == ST_WR_STAT || q.st == ST_RD_STAT)))
        |=> $stable(q.head)); // R7
    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst |=> !q.srst); // R10
    AST_STAT_OWN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && q.st == ST_WR_STAT) |-> !mem_wdata[OWN_BIT]); // R5

endmodule

// File: tb/ldma_rx_chan_bench.sv
module ldma_rx_chan_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_EN = 3'd0, A_RST = 3'd1, A_HEAD = 3'd2, A_CPL = 3'd3, A_CRED = 3'd4;
    localparam logic [31:0] M_SOP = 32'h8000_0000, M_EOP = 32'h4000_0000;
    localparam logic [31:0] M_OWN = 32'h2000_0000, M_EOQ = 32'h1000_0000;
    localparam logic [31:0] MODE_A = M_SOP | M_EOP | M_OWN | M_EOQ | 32'h0010_0000 | 32'h0000_07FF;

    logic        clk, rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        rx_valid, rx_last, rx_ready;
    logic [7:0]  rx_data;

    logic [31:0] mem [0:1023];
    int n_chk = 0, n_fail = 0, gcnt = 0, wd = 0;

    logic [31:0] ex_addr[$], ex_data[$];
    bit          ex_we[$];
    string       ex_tag[$];
    logic [31:0] ea, ed;
    bit          ew;
    string       et;

    ldma_rx_chan u_ldma_rx_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:2]];
    assign mem_gnt   = (gcnt % 3) != 2;
    always @(posedge clk) gcnt <= gcnt + 1;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Transaction-level model: every granted transfer is compared with the next expected one
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_gnt) begin
            if (ex_addr.size() == 0) begin
                chk(1'b0, "R1", "unexpected transfer", mem_addr, 32'h0);
            end else begin
                ea = ex_addr.pop_front(); ed = ex_data.pop_front();
                ew = ex_we.pop_front();   et = ex_tag.pop_front();
                chk(mem_addr == ea && mem_we == ew, et, "transfer address", mem_addr, ea);
                if (ew) chk(mem_wdata == ed, et, "write data", mem_wdata, ed);
            end
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            $display("FAIL R6 watchdog expired: actual %0d expected %0d", wd, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] pb(int seed, int i);
        return 8'(seed + i * 7 + 1);
    endfunction

    task automatic put_desc(int da, int nx, int ba, int bl, logic [31:0] md);
        mem[da >> 2]       = 32'(nx);
        mem[(da >> 2) + 1] = 32'(ba);
        mem[(da >> 2) + 2] = 32'(bl);
        mem[(da >> 2) + 3] = md;
    endtask

    task automatic exp_fetch(int da);
        for (int k = 0; k < 4; k++) begin
            ex_addr.push_back(32'(da + 4 * k)); ex_data.push_back(32'h0);
            ex_we.push_back(1'b0); ex_tag.push_back("R1");
        end
    endtask

    task automatic exp_done(int da, int nx, int ba, int bl, logic [31:0] md, int plen, int seed);
        int kept;
        logic [31:0] w;
        kept = (plen < bl) ? plen : bl;
        for (int k = 0; k * 4 < kept; k++) begin
            w = '0;
            for (int b = 0; b < 4; b++)
                if (k * 4 + b < kept) w[b*8 +: 8] = pb(seed, k * 4 + b);
            ex_addr.push_back(32'(ba + 4 * k)); ex_data.push_back(w);
            ex_we.push_back(1'b1); ex_tag.push_back((plen > bl) ? "R4" : "R3");
        end
        w = (md & ~(M_OWN | M_EOQ | 32'h7FF)) | ((nx == 0) ? M_EOQ : 32'h0) | 32'(kept);
        ex_addr.push_back(32'(da + 12)); ex_data.push_back(w);
        ex_we.push_back(1'b1); ex_tag.push_back("R5");
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic send_pkt(int len, int seed);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_data = pb(seed, i); rx_last = (i == len - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_head_zero();
        logic [31:0] v;
        do begin
            rd(A_HEAD, v);
            if (v != 0) @(negedge clk);
        end while (v != 0);
    endtask

    task automatic quiet(int n, string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            if (mem_req) seen++;
            @(negedge clk);
        end
        chk(seen == 0, tag, "memory request while channel must stay quiet", 32'(seen), 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R10)
        rd(A_EN, v);   chk(v == 0, "R10", "enable after reset", v, 0);
        rd(A_HEAD, v); chk(v == 0, "R10", "head after reset", v, 0);
        rd(A_CRED, v); chk(v == 0, "R10", "credit after reset", v, 0);
        chk(!mem_req && !rx_ready, "R10", "idle outputs after reset", {30'd0, mem_req, rx_ready}, 0);

        // R9: nothing fetched while disabled
        put_desc(32'h100, 0, 32'h800, 64, MODE_A);
        wr(A_CRED, 1);
        wr(A_HEAD, 32'h100);
        quiet(8, "R9");
        rd(A_HEAD, v); chk(v == 32'h100, "R9", "head held while disabled", v, 32'h100);
        exp_fetch(32'h100);
        exp_done(32'h100, 0, 32'h800, 64, MODE_A, 10, 3);
        wr(A_EN, 1);
        send_pkt(10, 3);
        wait_head_zero();
        chk(ex_addr.size() == 0, "R6", "single descriptor drained", 32'(ex_addr.size()), 0);
        rd(A_CRED, v); chk(v == 0, "R8", "credit consumed", v, 0);

        // R3/R4/R6: two-descriptor chain, second one truncated
        put_desc(32'h200, 32'h240, 32'h900, 64, MODE_A);
        put_desc(32'h240, 0, 32'hA00, 13, MODE_A);
        wr(A_CRED, 1); wr(A_CRED, 1);
        exp_fetch(32'h200); exp_done(32'h200, 32'h240, 32'h900, 64, MODE_A, 8, 5);
        exp_fetch(32'h240); exp_done(32'h240, 0, 32'hA00, 13, MODE_A, 20, 9);
        wr(A_HEAD, 32'h200);
        send_pkt(8, 5);
        send_pkt(20, 9);
        wait_head_zero();
        chk(ex_addr.size() == 0, "R6", "chain drained", 32'(ex_addr.size()), 0);
        rd(A_CRED, v); chk(v == 0, "R8", "two credits consumed", v, 0);

        // R8 no dry fetch, R7 busy head write, R8 coincident credit and completion
        put_desc(32'h300, 0, 32'hB00, 32, MODE_A);
        wr(A_HEAD, 32'h300);
        quiet(8, "R8");
        exp_fetch(32'h300); exp_done(32'h300, 0, 32'hB00, 32, MODE_A, 6, 11);
        wr(A_CRED, 1);
        while (!rx_ready) @(negedge clk);
        wr(A_HEAD, 32'h380);
        rd(A_HEAD, v); chk(v == 32'h300, "R7", "head write while busy ignored", v, 32'h300);
        send_pkt(6, 11);
        while (!(mem_req && mem_we && mem_gnt && mem_addr == 32'h30C)) @(negedge clk);
        wr(A_CRED, 1);
        wait_head_zero();
        rd(A_CRED, v); chk(v == 1, "R8", "credit add in completion cycle", v, 1);
        chk(ex_addr.size() == 0, "R7", "no fetch at ignored head", 32'(ex_addr.size()), 0);

        // R2: descriptor not owned
        put_desc(32'h400, 32'h440, 32'hC00, 16, M_SOP | M_EOP);
        exp_fetch(32'h400);
        wr(A_HEAD, 32'h400);
        wait_head_zero();
        chk(ex_addr.size() == 0, "R2", "unowned descriptor fetched only", 32'(ex_addr.size()), 0);
        rd(A_CRED, v); chk(v == 1, "R2", "credit kept on unowned", v, 1);
        chk(mem[32'h40C >> 2] == (M_SOP | M_EOP), "R2", "status untouched", mem[32'h40C >> 2], M_SOP | M_EOP);

        // R11: completion pointer
        wr(A_CPL, 32'h0000_0ABC);
        rd(A_CPL, v); chk(v == 32'h0000_0ABC, "R11", "completion pointer readback", v, 32'h0000_0ABC);
        rd(A_HEAD, v); chk(v == 0, "R11", "head unchanged by acknowledge", v, 0);
        quiet(4, "R11");

        // R10: soft reset mid-packet
        put_desc(32'h500, 0, 32'hD00, 16, MODE_A);
        exp_fetch(32'h500);
        wr(A_HEAD, 32'h500);
        while (!rx_ready) @(negedge clk);
        wr(A_RST, 1);
        rd(A_RST, v);  chk(v == 1, "R10", "reset bit visible one cycle", v, 1);
        @(negedge clk);
        rd(A_RST, v);  chk(v == 0, "R10", "reset bit self-clears", v, 0);
        rd(A_HEAD, v); chk(v == 0, "R10", "head cleared", v, 0);
        rd(A_CRED, v); chk(v == 0, "R10", "credit cleared", v, 0);
        rd(A_EN, v);   chk(v == 0, "R10", "enable cleared", v, 0);
        rd(A_CPL, v);  chk(v == 0, "R10", "completion pointer cleared", v, 0);
        chk(!rx_ready, "R10", "stream closed after reset", {31'd0, rx_ready}, 0);
        quiet(6, "R10");

        // R5/R6: end of queue then restart with a rewritten head
        wr(A_EN, 1); wr(A_CRED, 1); wr(A_CRED, 1);
        put_desc(32'h600, 0, 32'hE00, 8, MODE_A);
        exp_fetch(32'h600); exp_done(32'h600, 0, 32'hE00, 8, MODE_A, 8, 13);
        wr(A_HEAD, 32'h600);
        send_pkt(8, 13);
        wait_head_zero();
        chk(mem[32'h60C >> 2][28] == 1'b1, "R5", "end-of-queue flag set", {31'd0, mem[32'h60C >> 2][28]}, 1);
        mem[32'h600 >> 2] = 32'h640;
        put_desc(32'h640, 0, 32'hF00, 40, MODE_A);
        exp_fetch(32'h640); exp_done(32'h640, 0, 32'hF00, 40, MODE_A, 3, 17);
        wr(A_HEAD, 32'h640);
        send_pkt(3, 17);
        wait_head_zero();
        chk(ex_addr.size() == 0, "R6", "restart drained", 32'(ex_addr.size()), 0);
        rd(A_CRED, v); chk(v == 0, "R8", "credits after restart", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule